// File: doc/BRIEF.md
# Paired-Node Quarter-Wave Table Fetch

This block fetches the four operands that a cubic Hermite interpolator needs for one interval of a quarter-wave sine. It holds a single table of sine amplitudes over the first quadrant. Each word of the table carries two neighbouring node amplitudes. The caller presents a folded interval index `k`. One read port returns the amplitude pair for nodes `k` and `k+1`. The second port reads the same table at the mirrored address. Because the cosine of a phase equals the sine of its complement, that read gives the slopes at both nodes. The two ports together replace separate amplitude and derivative memories.

The table is computed at elaboration: word `i` holds `S(i)` in its upper half and `S(i+1)` in its lower half, with `S(j) = round((2^AMP_W - 1) * sin(j * pi / (2 * NODES)))`. A request passes through two register stages. The first decodes and clamps the addresses. The second registers the table words. The registered words are then split into the two amplitudes and the two slopes. Phase accumulation, quadrant folding and the interpolation arithmetic belong to the neighbouring blocks.

Top module: `qw_pair_fetch`

## Requirements
- R1: `rsp_vld` is high exactly two clock cycles after a cycle in which `req_vld` is sampled high, and is low otherwise.
- R2: For an in-range index `k` (0 to NODES-1), `amp_lo` equals `S(k)` and `amp_hi` equals `S(k+1)`. The table word's upper half is decoded as the lower node and its lower half as the upper node.
- R3: For an in-range index `k`, `slope_lo` equals `S(NODES-k)` and `slope_hi` equals `S(NODES-k-1)`. These are the cosines at nodes `k` and `k+1`, read from the mirrored word `NODES-1-k` with its halves swapped.
- R4: An index of NODES or more is treated as NODES-1, so every output equals the result for index NODES-1.
- R5: While `rst_n` is low, `rsp_vld` and all four operand outputs are zero.
- R6: Requests on consecutive cycles are served back to back, each result appearing in its own cycle in request order.
- R7: In a cycle where `rsp_vld` is low after reset, the four operand outputs keep the values of the last response; `req_idx` presented without `req_vld` has no effect.
- R8: The quadrant edges are exact. At `k = 0` the outputs give `amp_lo = 0` and `slope_lo = 2^AMP_W - 1`. At `k = NODES-1` they give `amp_hi = 2^AMP_W - 1` and `slope_hi = 0`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_vld | input | 1 | Request strobe for `req_idx` |
| req_idx | input | $clog2(NODES)+1 | Folded interval index `k` |
| rsp_vld | output | 1 | Operands below belong to a request |
| amp_lo | output | AMP_W | Amplitude at node `k` |
| amp_hi | output | AMP_W | Amplitude at node `k+1` |
| slope_lo | output | AMP_W | Slope (cosine) at node `k` |
| slope_hi | output | AMP_W | Slope (cosine) at node `k+1` |

## Verification
A wrong mirrored address or a missed half swap shows at the ports two cycles after the request. It appears as slopes that rise with `k` instead of falling, or as a slope pair that disagrees with the amplitude pair of the complementary index. A bad clamp can only be seen on indices at or above NODES, so the sweep covers every value of `req_idx`. A stage that loads without a strobe shows within two cycles as operands changing while `rsp_vld` is low.

// File: rtl/qw_fetch_pkg.sv
package qw_fetch_pkg;

    localparam real QW_PI = 3.14159265358979323846;

    // Rounded first-quadrant sine sample j of a table with `nodes` intervals.
    function automatic int qw_sample(input int j, input int nodes, input int amp_w);
        real full;
        real ang;
        full = real'((1 << amp_w) - 1);
        ang  = real'(j) * QW_PI / (2.0 * real'(nodes));
        return $rtoi(full * $sin(ang) + 0.5);
    endfunction

endpackage

// File: rtl/qw_addr_decode.sv
module qw_addr_decode #(
    parameter int NODES = 16,
    localparam int IDX_W  = $clog2(NODES) + 1,
    localparam int ADDR_W = $clog2(NODES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_vld,
    input  logic [IDX_W-1:0]  req_idx,
    output logic              dec_vld,
    output logic [ADDR_W-1:0] addr_amp,
    output logic [ADDR_W-1:0] addr_slp
);
    typedef struct packed {
        logic              vld;
        logic [ADDR_W-1:0] amp;
        logic [ADDR_W-1:0] slp;
    } dec_t;

    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(NODES - 1);

    dec_t st_d, st_q;
    logic [ADDR_W-1:0] k_clamped;

    always_comb begin
        st_d     = st_q;
        st_d.vld = req_vld;
        if (req_idx >= IDX_W'(NODES)) begin
            k_clamped = LAST;
        end else begin
            k_clamped = req_idx[ADDR_W-1:0];
        end
        if (req_vld) begin
            st_d.amp = k_clamped;
            st_d.slp = LAST - k_clamped;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dec_vld  = st_q.vld;
    assign addr_amp = st_q.amp;
    assign addr_slp = st_q.slp;
endmodule

// File: rtl/qw_rom_dp.sv
module qw_rom_dp
    import qw_fetch_pkg::*;
#(
    parameter int NODES = 16,
    parameter int AMP_W = 12,
    localparam int ADDR_W = $clog2(NODES),
    localparam int WORD_W = 2 * AMP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr_a,
    input  logic [ADDR_W-1:0] addr_b,
    output logic              rd_vld,
    output logic [WORD_W-1:0] word_a,
    output logic [WORD_W-1:0] word_b
);
    typedef struct packed {
        logic              vld;
        logic [WORD_W-1:0] wa;
        logic [WORD_W-1:0] wb;
    } rd_t;

    logic [WORD_W-1:0] tbl [NODES];

    for (genvar g = 0; g < NODES; g++) begin : g_word
        localparam int LO_NODE = qw_sample(g, NODES, AMP_W);
        localparam int HI_NODE = qw_sample(g + 1, NODES, AMP_W);
        assign tbl[g] = {AMP_W'(LO_NODE), AMP_W'(HI_NODE)};
    end

    rd_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.vld = rd_en;
        if (rd_en) begin
            st_d.wa = tbl[addr_a];
            st_d.wb = tbl[addr_b];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_vld = st_q.vld;
    assign word_a = st_q.wa;
    assign word_b = st_q.wb;
endmodule

// File: rtl/qw_pair_fetch.sv
module qw_pair_fetch #(
    parameter int NODES = 16,
    parameter int AMP_W = 12,
    localparam int IDX_W  = $clog2(NODES) + 1,
    localparam int ADDR_W = $clog2(NODES),
    localparam int WORD_W = 2 * AMP_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_vld,
    input  logic [IDX_W-1:0] req_idx,
    output logic             rsp_vld,
    output logic [AMP_W-1:0] amp_lo,
    output logic [AMP_W-1:0] amp_hi,
    output logic [AMP_W-1:0] slope_lo,
    output logic [AMP_W-1:0] slope_hi
);
    logic              dec_vld;
    logic [ADDR_W-1:0] addr_amp;
    logic [ADDR_W-1:0] addr_slp;
    logic [WORD_W-1:0] word_amp;
    logic [WORD_W-1:0] word_slp;

    qw_addr_decode #(.NODES(NODES)) u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_vld  (req_vld),
        .req_idx  (req_idx),
        .dec_vld  (dec_vld),
        .addr_amp (addr_amp),
        .addr_slp (addr_slp)
    );

    qw_rom_dp #(.NODES(NODES), .AMP_W(AMP_W)) u_rom (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_en  (dec_vld),
        .addr_a (addr_amp),
        .addr_b (addr_slp),
        .rd_vld (rsp_vld),
        .word_a (word_amp),
        .word_b (word_slp)
    );

    // Amplitude word: node k in the upper half, node k+1 in the lower half.
    assign amp_lo   = word_amp[WORD_W-1:AMP_W];
    assign amp_hi   = word_amp[AMP_W-1:0];
    // Mirrored word NODES-1-k holds S(NODES-k-1) high and S(NODES-k) low:
    // node order is reversed, so the halves are swapped.
    assign slope_lo = word_slp[AMP_W-1:0];
    assign slope_hi = word_slp[WORD_W-1:AMP_W];
endmodule

// File: rtl/qw_pair_fetch_chk.sv
module qw_pair_fetch_chk #(
    parameter int NODES = 16,
    parameter int AMP_W = 12,
    localparam int IDX_W = $clog2(NODES) + 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_vld,
    input logic [IDX_W-1:0] req_idx,
    input logic             rsp_vld,
    input logic [AMP_W-1:0] amp_lo,
    input logic [AMP_W-1:0] amp_hi,
    input logic [AMP_W-1:0] slope_lo,
    input logic [AMP_W-1:0] slope_hi
);
    logic [1:0] since_rst_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_rst_q <= '0;
        end else if (since_rst_q != 2'd3) begin
            since_rst_q <= since_rst_q + 2'd1;
        end
    end

    p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst_q >= 2'd2) |-> (rsp_vld == $past(req_vld, 2)));

    p_amp_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_vld |-> (amp_lo <= amp_hi));

    p_slope_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_vld |-> (slope_lo >= slope_hi));

    p_reset_quiet_r5: assert property (@(posedge clk)
        !rst_n |=> !rsp_vld);

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((since_rst_q >= 2'd1) && !rsp_vld) |->
            ($stable(amp_lo) && $stable(amp_hi) && $stable(slope_lo) && $stable(slope_hi)));
endmodule

bind qw_pair_fetch qw_pair_fetch_chk #(.NODES(NODES), .AMP_W(AMP_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_vld  (req_vld),
    .req_idx  (req_idx),
    .rsp_vld  (rsp_vld),
    .amp_lo   (amp_lo),
    .amp_hi   (amp_hi),
    .slope_lo (slope_lo),
    .slope_hi (slope_hi)
);

// File: tb/tb_qw_pair_fetch.sv
`timescale 1ns/1ps
module tb_qw_pair_fetch;
    localparam int NODES = 16;
    localparam int AMP_W = 12;
    localparam int IDX_W = $clog2(NODES) + 1;
    localparam int FULL  = (1 << AMP_W) - 1;
    localparam real PI   = 3.14159265358979323846;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_vld = 1'b0;
    logic [IDX_W-1:0] req_idx = '0;
    logic             rsp_vld;
    logic [AMP_W-1:0] amp_lo, amp_hi, slope_lo, slope_hi;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    // pipeline of requests in flight: [0] one step ago, [1] two steps ago
    bit hv [2];
    int hk [2];
    int last_e [4];

    always #5 clk = ~clk;

    qw_pair_fetch #(.NODES(NODES), .AMP_W(AMP_W)) dut (
        .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_idx(req_idx),
        .rsp_vld(rsp_vld), .amp_lo(amp_lo), .amp_hi(amp_hi),
        .slope_lo(slope_lo), .slope_hi(slope_hi)
    );

    function automatic int sv(input int j);
        return $rtoi(real'(FULL) * $sin(real'(j) * PI / (2.0 * real'(NODES))) + 0.5);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // compare the response visible now against the request made two steps ago
    task automatic check_slot();
        int k;
        check("R1 rsp_vld", int'(rsp_vld), int'(hv[1]));
        if (hv[1]) begin
            k = (hk[1] >= NODES) ? NODES - 1 : hk[1];
            last_e[0] = sv(k);
            last_e[1] = sv(k + 1);
            last_e[2] = sv(NODES - k);
            last_e[3] = sv(NODES - k - 1);
            if (hk[1] >= NODES) begin
                check("R4 clamp amp_lo", int'(amp_lo), last_e[0]);
                check("R4 clamp slope_hi", int'(slope_hi), last_e[3]);
            end
            check("R2 amp_lo", int'(amp_lo), last_e[0]);
            check("R2 amp_hi", int'(amp_hi), last_e[1]);
            check("R3 slope_lo", int'(slope_lo), last_e[2]);
            check("R3 slope_hi", int'(slope_hi), last_e[3]);
        end else begin
            check("R7 hold amp_lo", int'(amp_lo), last_e[0]);
            check("R7 hold amp_hi", int'(amp_hi), last_e[1]);
            check("R7 hold slope_lo", int'(slope_lo), last_e[2]);
            check("R7 hold slope_hi", int'(slope_hi), last_e[3]);
        end
    endtask

    task automatic step(input bit v, input int idx);
        @(negedge clk);
        check_slot();
        hv[1] = hv[0]; hk[1] = hk[0];
        hv[0] = v;     hk[0] = idx;
        req_vld = v;
        req_idx = IDX_W'(idx);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=expired expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        int lfsr;
        hv[0] = 1'b0; hv[1] = 1'b0; hk[0] = 0; hk[1] = 0;
        for (int i = 0; i < 4; i++) last_e[i] = 0;

        // R5: reset state, even with a request strobed during reset
        req_vld = 1'b1; req_idx = IDX_W'(3);
        repeat (3) @(negedge clk);
        check("R5 rsp_vld in reset", int'(rsp_vld), 0);
        check("R5 amp_lo in reset", int'(amp_lo), 0);
        check("R5 amp_hi in reset", int'(amp_hi), 0);
        check("R5 slope_lo in reset", int'(slope_lo), 0);
        check("R5 slope_hi in reset", int'(slope_hi), 0);
        req_vld = 1'b0;
        rst_n = 1'b1;

        // R6: back-to-back sweep over every index value (includes R4 range)
        for (int i = 0; i < (1 << IDX_W); i++) step(1'b1, i);
        step(1'b0, 0);
        step(1'b0, 0);

        // R8: quadrant edges
        step(1'b1, 0);
        step(1'b0, 5);
        step(1'b0, 9);
        check("R8 edge k=0 amp_lo", int'(amp_lo), 0);
        check("R8 edge k=0 slope_lo", int'(slope_lo), FULL);
        step(1'b1, NODES - 1);
        step(1'b0, 2);
        step(1'b0, 7);
        check("R8 edge k=N-1 amp_hi", int'(amp_hi), FULL);
        check("R8 edge k=N-1 slope_hi", int'(slope_hi), 0);

        // R7: strobe gaps with changing index; R6 irregular valid pattern
        lfsr = 32'h5a3;
        for (int i = 0; i < 200; i++) begin
            lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hB400 : 0);
            step(((lfsr >> 3) & 1) == 1, lfsr % (1 << IDX_W));
        end
        step(1'b0, 1);
        step(1'b0, 2);
        step(1'b0, 3);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule